// File: doc/BRIEF.md
# Push-Button Power-Up Sequencer

This block is the control core of a seven-rail power-management unit. It turns the rails on in stages when a start event arrives. A start event is either the active-low push-button going low, or the charger-valid input rising. The first stage powers rail 5 alone. Each later stage begins once a chosen rail's power-good flag has stayed high for a set number of millisecond ticks. Every delay counts pulses on a one-cycle tick input, so time can be scaled freely.

The processor keeps the system alive through a hold input:

- **Button start:** hold must arrive before the button is released. Otherwise every rail is switched off.
- **Charger start:** hold must arrive within a timeout window. Otherwise every rail is switched off.
- **After hold is seen:** the rails stay on while hold stays high. If hold drops while the button is released, all rails go off at the same clock edge.
- **Power-enable input:** while a sequence is running, this processor input forces rails 2, 3, 4, 6 and 7 on.

Top module: `pb_power_seq`

## Requirements
- R1: While reset is asserted, and after it is released with no start event, every bit of `rail_en_o` is 0 and `seq_state_o` is 0.
- R2: `btn_n_i` low while idle starts a sequence at the next clock edge. After that edge only rail 5 is enabled: `rail_en_o` = 7'b0010000, where bit i drives rail i+1. `seq_state_o` is 1.
- R3: A rising edge of `chg_ok_i` while idle starts the same sequence as R2. If `chg_ok_i` stays high after that, no new sequence starts.
- R4: Rails 2, 3 and 4 turn on at the edge where rail 5's power-good flag completes `T_R5_MS` consecutive ticks while high. A low flag before completion restarts that count from zero. `seq_state_o` becomes 2 at that edge.
- R5: Rails 1 and 6 turn on once rail 2's power-good flag has been high for `T_R2A_MS` ticks (default 8). `seq_state_o` becomes 3.
- R6: Rail 7 turns on once rail 2's power-good flag has been high for `T_R2B_MS` ticks (default 16). `seq_state_o` becomes 4.
- R7: After a button start, releasing the button before `cpu_hold_i` is seen clears every enable at the next edge, and `seq_state_o` becomes 0.
- R8: After a charger start, if `cpu_hold_i` is not seen within `HOLD_WIN_MS` ticks, every enable clears. With the default of 260, this happens at the edge of the 260th tick after the start edge.
- R9: Once `cpu_hold_i` has been seen, the rails stay on with the button released. `cpu_hold_i` low with the button released clears every enable at the next edge.
- R10: While a sequence is active, `cpu_pwr_en_i` high forces rails 2, 3, 4, 6 and 7 on in the same cycle. While idle, it has no effect.
- R11: No delay counter advances in a cycle where `ms_tick_i` is low.
- R12: `seq_state_o` encoding: 0 idle, 1 rail 5 only, 2 rails 2-4 added, 3 rails 1 and 6 added, 4 rail 7 added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| btn_n_i | input | 1 | Push-button, active low |
| chg_ok_i | input | 1 | Charger input valid |
| cpu_hold_i | input | 1 | Processor keep-alive |
| cpu_pwr_en_i | input | 1 | Processor power enable for rails 2,3,4,6,7 |
| pgood_i | input | 7 | Power-good flags, bit i for rail i+1 |
| ms_tick_i | input | 1 | One-cycle millisecond tick |
| rail_en_o | output | 7 | Rail enables, bit i for rail i+1 |
| seq_state_o | output | 3 | Sequence stage (R12 encoding) |

## Verification
A wrong phase register shows up at the next edge in two ways. Rail 5's enable and `seq_state_o` disagree with the start or abort that was just applied. Rails also stay on after a release that should have dropped them.

A miscounted stability or window timer moves a stage change, or the charger timeout, by one or more ticks. The bench pins every such change to the exact cycle.

A bad power-enable decode shows in the same cycle as the input change.

// File: rtl/pwrseq_pkg.sv
// Shared types and constants for the push-button power sequencer.
// Assumes seven rails; bit i of every rail vector belongs to rail i+1.
package pwrseq_pkg;
    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_WAIT = 2'd1,
        PH_HELD = 2'd2
    } phase_t;

    localparam int unsigned NUM_RAILS = 7;
    localparam int unsigned RAIL1 = 0;
    localparam int unsigned RAIL2 = 1;
    localparam int unsigned RAIL3 = 2;
    localparam int unsigned RAIL4 = 3;
    localparam int unsigned RAIL5 = 4;
    localparam int unsigned RAIL6 = 5;
    localparam int unsigned RAIL7 = 6;

    localparam logic [2:0] STG_OFF  = 3'd0;
    localparam logic [2:0] STG_R5   = 3'd1;
    localparam logic [2:0] STG_R234 = 3'd2;
    localparam logic [2:0] STG_R16  = 3'd3;
    localparam logic [2:0] STG_ALL  = 3'd4;
endpackage

// File: rtl/pg_hold_timer.sv
// Power-good stability timer: raises done once pg_i has stayed high for
// LEN_MS consecutive ticks. A low pg_i before completion restarts the count.
// done is sticky until clr_i. Assumes tick_i is a one-cycle pulse.
module pg_hold_timer #(
    parameter int unsigned LEN_MS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic pg_i,
    input  logic tick_i,
    output logic done_o
);
    localparam int unsigned CW = $clog2(LEN_MS + 1);

    logic [CW-1:0] cnt_q;

    // Count ticks of continuous power-good, latch done at the last one.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q  <= '0;
            done_o <= 1'b0;
        end else if (!done_o) begin
            if (!pg_i) begin
                cnt_q <= '0;
            end else if (tick_i) begin
                if (cnt_q == CW'(LEN_MS - 1)) begin
                    done_o <= 1'b1;
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R11
    done_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(tick_i));

    // R4
    done_needs_pg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(pg_i));
endmodule

// File: rtl/seq_ctrl.sv
// Phase controller: detects start events, then waits for the processor
// hold while watching the button (button start) or a tick window (charger
// start). Assumes btn_n_i and chg_ok_i are already synchronised.
module seq_ctrl
    import pwrseq_pkg::*;
#(
    parameter int unsigned HOLD_WIN_MS = 260
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   btn_n_i,
    input  logic   chg_ok_i,
    input  logic   hold_i,
    input  logic   tick_i,
    output phase_t phase_o
);
    localparam int unsigned WW = $clog2(HOLD_WIN_MS + 1);

    phase_t        phase_d;
    logic          chg_q;
    logic          from_chg_q;
    logic          from_chg_d;
    logic [WW-1:0] win_cnt_q;
    logic          chg_rise;
    logic          win_last;

    assign chg_rise = chg_ok_i && !chg_q;
    assign win_last = tick_i && (win_cnt_q == WW'(HOLD_WIN_MS - 1));

    // Next-phase decision from start events, hold and abort conditions.
    always_comb begin
        phase_d    = phase_o;
        from_chg_d = from_chg_q;
        case (phase_o)
            PH_OFF: begin
                if (!btn_n_i) begin
                    phase_d    = PH_WAIT;
                    from_chg_d = 1'b0;
                end else if (chg_rise) begin
                    phase_d    = PH_WAIT;
                    from_chg_d = 1'b1;
                end
            end
            PH_WAIT: begin
                if (hold_i)
                    phase_d = PH_HELD;
                else if (from_chg_q ? win_last : btn_n_i)
                    phase_d = PH_OFF;
            end
            PH_HELD: begin
                if (!hold_i && btn_n_i)
                    phase_d = PH_OFF;
            end
            default: phase_d = PH_OFF;
        endcase
    end

    // Phase, start-source and charger edge registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_o    <= PH_OFF;
            from_chg_q <= 1'b0;
            chg_q      <= 1'b0;
        end else begin
            phase_o    <= phase_d;
            from_chg_q <= from_chg_d;
            chg_q      <= chg_ok_i;
        end
    end

    // Hold window counter, running only while waiting for hold.
    always_ff @(posedge clk) begin
        if (!rst_n || phase_o != PH_WAIT)
            win_cnt_q <= '0;
        else if (tick_i)
            win_cnt_q <= win_cnt_q + 1'b1;
    end

    // R7
    btn_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_WAIT && !from_chg_q && btn_n_i && !hold_i)
        |=> (phase_o == PH_OFF));

    // R8
    chg_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_WAIT && from_chg_q && win_last && !hold_i)
        |=> (phase_o == PH_OFF));

    // R9
    hold_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_HELD && !hold_i && btn_n_i) |=> (phase_o == PH_OFF));

    // R9
    held_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_HELD && hold_i) |=> (phase_o == PH_HELD));
endmodule

// File: rtl/rail_decode.sv
// Rail enable and stage decode from the active phase, the three stability
// timer results and the processor power enable. Purely combinational.
module rail_decode
    import pwrseq_pkg::*;
(
    input  logic                 active_i,
    input  logic                 pwr_en_i,
    input  logic                 r5_ok_i,
    input  logic                 r2_short_ok_i,
    input  logic                 r2_long_ok_i,
    output logic [NUM_RAILS-1:0] rail_en_o,
    output logic [2:0]           stage_o
);
    // Per-rail enable terms.
    always_comb begin
        rail_en_o        = '0;
        rail_en_o[RAIL5] = active_i;
        rail_en_o[RAIL2] = active_i && (r5_ok_i || pwr_en_i);
        rail_en_o[RAIL3] = active_i && (r5_ok_i || pwr_en_i);
        rail_en_o[RAIL4] = active_i && (r5_ok_i || pwr_en_i);
        rail_en_o[RAIL1] = active_i && r2_short_ok_i;
        rail_en_o[RAIL6] = active_i && (r2_short_ok_i || pwr_en_i);
        rail_en_o[RAIL7] = active_i && (r2_long_ok_i || pwr_en_i);
    end

    // Stage code, furthest completed step wins.
    always_comb begin
        if (!active_i)          stage_o = STG_OFF;
        else if (r2_long_ok_i)  stage_o = STG_ALL;
        else if (r2_short_ok_i) stage_o = STG_R16;
        else if (r5_ok_i)       stage_o = STG_R234;
        else                    stage_o = STG_R5;
    end
endmodule

// File: rtl/pb_power_seq.sv
// Push-button power-up sequencer top: phase controller, three power-good
// stability timers (rail 5 short, rail 2 short, rail 2 long) and the rail
// decode. Assumes all inputs are synchronous to clk.
module pb_power_seq
    import pwrseq_pkg::*;
#(
    parameter int unsigned T_R5_MS     = 8,
    parameter int unsigned T_R2A_MS    = 8,
    parameter int unsigned T_R2B_MS    = 16,
    parameter int unsigned HOLD_WIN_MS = 260
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       btn_n_i,
    input  logic       chg_ok_i,
    input  logic       cpu_hold_i,
    input  logic       cpu_pwr_en_i,
    input  logic [6:0] pgood_i,
    input  logic       ms_tick_i,
    output logic [6:0] rail_en_o,
    output logic [2:0] seq_state_o
);
    localparam int unsigned NT = 3;
    localparam int unsigned TLEN [NT] = '{T_R5_MS, T_R2A_MS, T_R2B_MS};
    localparam int unsigned TSRC [NT] = '{RAIL5, RAIL2, RAIL2};

    phase_t        phase;
    logic          active;
    logic [NT-1:0] t_done;
    logic          unused_pg_bits;

    assign active         = (phase != PH_OFF);
    assign unused_pg_bits = ^{pgood_i[RAIL1], pgood_i[RAIL3], pgood_i[RAIL4],
                              pgood_i[RAIL6], pgood_i[RAIL7]};

    seq_ctrl #(.HOLD_WIN_MS(HOLD_WIN_MS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .btn_n_i  (btn_n_i),
        .chg_ok_i (chg_ok_i),
        .hold_i   (cpu_hold_i),
        .tick_i   (ms_tick_i),
        .phase_o  (phase)
    );

    // One stability timer per staging condition, gated by its rail enable.
    for (genvar g = 0; g < NT; g++) begin : g_tmr
        pg_hold_timer #(.LEN_MS(TLEN[g])) u_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (!active),
            .pg_i   (pgood_i[TSRC[g]] && rail_en_o[TSRC[g]]),
            .tick_i (ms_tick_i),
            .done_o (t_done[g])
        );
    end

    rail_decode u_dec (
        .active_i      (active),
        .pwr_en_i      (cpu_pwr_en_i),
        .r5_ok_i       (t_done[0]),
        .r2_short_ok_i (t_done[1]),
        .r2_long_ok_i  (t_done[2]),
        .rail_en_o     (rail_en_o),
        .stage_o       (seq_state_o)
    );

    // R2
    r5_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_en_o != '0) |-> rail_en_o[RAIL5]);

    // R6
    r7_after_r1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_en_o[RAIL7] && !cpu_pwr_en_i) |-> rail_en_o[RAIL1]);

    // R10
    pwr_en_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state_o != STG_OFF && cpu_pwr_en_i) |-> (rail_en_o[6:1] == 6'b111111));

    // R12
    stage_matches_r5_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state_o != STG_OFF) == rail_en_o[RAIL5]);

    // R2
    start_from_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(seq_state_o) == STG_OFF && $past(!btn_n_i)) |-> (seq_state_o == STG_R5));
endmodule

// File: tb/sim_pb_power_seq.sv
// Scoreboard bench: the driver sets inputs and pushes the expected outputs
// for each cycle; the monitor pops and compares them at every falling edge.
module sim_pb_power_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       btn_n = 1'b1;
    logic       chg = 1'b0;
    logic       hold = 1'b0;
    logic       pwen = 1'b0;
    logic [6:0] pg = 7'h7f;
    logic       tick = 1'b0;
    logic [6:0] rail_en;
    logic [2:0] st;

    int n_run  = 0;
    int n_fail = 0;
    int n_cyc  = 0;

    typedef struct {
        logic       chk;
        logic [6:0] en;
        logic [2:0] st;
        string      req;
    } exp_t;

    exp_t sb_q[$];

    always #2 clk = ~clk;

    pb_power_seq u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .btn_n_i      (btn_n),
        .chg_ok_i     (chg),
        .cpu_hold_i   (hold),
        .cpu_pwr_en_i (pwen),
        .pgood_i      (pg),
        .ms_tick_i    (tick),
        .rail_en_o    (rail_en),
        .seq_state_o  (st)
    );

    task automatic cyc(input logic [6:0] e, input logic [2:0] s, input string r);
        exp_t it;
        it.chk = 1'b1; it.en = e; it.st = s; it.req = r;
        sb_q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            exp_t it;
            it.chk = 1'b0; it.en = '0; it.st = '0; it.req = "";
            sb_q.push_back(it);
            @(negedge clk); #1;
        end
    endtask

    // Full staging with constant tick and power-good; first item tagged t1.
    task automatic stages(input string t1);
        cyc(7'b0010000, 3'd1, t1);
        for (int i = 2; i <= 8; i++) cyc(7'b0010000, 3'd1, "R2");
        for (int i = 9; i <= 16; i++) cyc(7'b0011110, 3'd2, "R4");
        for (int i = 17; i <= 24; i++) cyc(7'b0111111, 3'd3, "R5");
        cyc(7'b1111111, 3'd4, "R6");
    endtask

    // Monitor: compare the oldest expectation with the outputs.
    always @(negedge clk) begin
        n_cyc++;
        if (sb_q.size() > 0) begin
            exp_t it;
            it = sb_q.pop_front();
            if (it.chk) begin
                n_run++;
                if (rail_en !== it.en || st !== it.st) begin
                    n_fail++;
                    $display("FAIL %s: rail_en=%b state=%0d expected rail_en=%b state=%0d",
                             it.req, rail_en, st, it.en, it.st);
                end
            end
        end
        if (n_cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected completion", n_cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk); #1;
        // R1: reset state
        idle(1);
        cyc(7'b0, 3'd0, "R1");
        rst_n = 1'b1;
        cyc(7'b0, 3'd0, "R1");
        cyc(7'b0, 3'd0, "R1");

        // Button start, hold, release, hold drop (R2 R4 R5 R6 R9 R12)
        tick = 1'b1; btn_n = 1'b0;
        for (int i = 1; i <= 8; i++) cyc(7'b0010000, 3'd1, "R2");
        for (int i = 9; i <= 16; i++) cyc(7'b0011110, 3'd2, "R4");
        for (int i = 17; i <= 24; i++) cyc(7'b0111111, 3'd3, "R5");
        hold = 1'b1;
        cyc(7'b1111111, 3'd4, "R6");
        btn_n = 1'b1;
        for (int i = 0; i < 3; i++) cyc(7'b1111111, 3'd4, "R9");
        hold = 1'b0;
        cyc(7'b0, 3'd0, "R9");
        cyc(7'b0, 3'd0, "R9");

        // Early button release aborts (R7)
        btn_n = 1'b0;
        for (int i = 0; i < 3; i++) cyc(7'b0010000, 3'd1, "R2");
        btn_n = 1'b1;
        cyc(7'b0, 3'd0, "R7");
        cyc(7'b0, 3'd0, "R7");

        // Power-good glitch restarts the rail 5 count (R4)
        btn_n = 1'b0;
        for (int i = 0; i < 5; i++) cyc(7'b0010000, 3'd1, "R4");
        pg[4] = 1'b0;
        cyc(7'b0010000, 3'd1, "R4");
        pg[4] = 1'b1;
        for (int i = 0; i < 7; i++) cyc(7'b0010000, 3'd1, "R4");
        cyc(7'b0011110, 3'd2, "R4");
        btn_n = 1'b1;
        cyc(7'b0, 3'd0, "R7");

        // Counting only on tick (R11)
        tick = 1'b0; btn_n = 1'b0;
        for (int i = 0; i < 20; i++) cyc(7'b0010000, 3'd1, "R11");
        tick = 1'b1;
        for (int i = 0; i < 7; i++) cyc(7'b0010000, 3'd1, "R11");
        cyc(7'b0011110, 3'd2, "R11");
        btn_n = 1'b1;
        cyc(7'b0, 3'd0, "R7");

        // Power enable: no effect idle, forces rails while active (R10)
        tick = 1'b0; pwen = 1'b1;
        cyc(7'b0, 3'd0, "R10");
        cyc(7'b0, 3'd0, "R10");
        btn_n = 1'b0;
        for (int i = 0; i < 3; i++) cyc(7'b1111110, 3'd1, "R10");
        pwen = 1'b0;
        cyc(7'b0010000, 3'd1, "R10");
        btn_n = 1'b1;
        cyc(7'b0, 3'd0, "R7");

        // Charger start without hold times out (R3 R8)
        tick = 1'b1; chg = 1'b1;
        stages("R3");
        for (int i = 26; i <= 259; i++) idle(1);
        cyc(7'b1111111, 3'd4, "R8");
        cyc(7'b0, 3'd0, "R8");
        for (int i = 0; i < 3; i++) cyc(7'b0, 3'd0, "R3");
        chg = 1'b0;
        cyc(7'b0, 3'd0, "R3");

        // Charger start with hold survives the window, then hold drop (R9)
        chg = 1'b1;
        stages("R3");
        idle(5);
        hold = 1'b1;
        idle(260);
        cyc(7'b1111111, 3'd4, "R9");
        hold = 1'b0;
        cyc(7'b0, 3'd0, "R9");
        chg = 1'b0;
        idle(2);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule